// File: doc/BRIEF.md
# Decoupled Fetch Queue with Restart

This block is the buffer between an instruction fetch unit and an execution back end. Every fetched instruction is stored with the program counter the front end guessed for it. The two are kept in two storage lanes that are written and read together. Each cycle the fetch side may hand over two entries and the back end takes one. This lets the front end run ahead, so that fetch stalls and back-end cache misses overlap instead of holding each other up.

When the back end resolves control flow, it presents the architecturally correct next PC. If the queue holds entries, that value is compared with the guessed PC of the entry at the head. If the two differ, every queued entry is on a wrong path. The queue is then emptied at once, and in the next cycle a one-cycle restart pulse tells the front end where to fetch from.

Control is a two-state machine. `S_RUN` is normal operation. `S_RESTART` lasts exactly one cycle and drives the restart pulse. Transition MISMATCH goes from `S_RUN` to `S_RESTART` on a head mismatch. Transition RESUME goes from `S_RESTART` back to `S_RUN` unconditionally. In `S_RUN` with no mismatch, the state holds. The depth must be a power of two.

Top module: `fetch_decouple_q`

## Requirements
- R1: After reset, `head_valid` is 0, `restart_valid` is 0 and `fetch_ready` is 1.
- R2: Entries leave in arrival order. When both lanes push in one cycle, lane 0's entry precedes lane 1's. Each entry's instruction and guessed PC are presented together at the head.
- R3: A push with only one lane valid (either lane 0 or lane 1 alone) adds exactly one entry.
- R4: `fetch_ready` is 1 exactly when at least two of the DEPTH (default 8) slots are free. Pushes while it is 0 are dropped, and the occupancy never exceeds DEPTH.
- R5: `deq` removes one entry per cycle. `deq` on an empty queue has no effect.
- R6: A resolve whose PC equals the head's guessed PC causes no restart and leaves the queue contents unchanged.
- R7: A resolve whose PC differs from the head's guessed PC, while the queue is non-empty, makes `restart_valid` 1 in the next cycle for exactly one cycle, with `restart_pc` equal to the resolved PC.
- R8: The flush has priority. In the cycle after a mismatch the queue is empty, and any push or `deq` in the mismatch cycle has no effect.
- R9: While `restart_valid` is 1, `fetch_ready` is 0 and pushes are dropped. In the following cycle the queue accepts pushes again.
- R10: A resolve while the queue is empty never causes a restart.
- R11: A push and a `deq` in the same cycle change the occupancy by the number pushed minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_v0 | input | 1 | Lane 0 push valid (older of the pair) |
| fe_instr0 | input | IW | Lane 0 instruction |
| fe_pc0 | input | AW | Lane 0 guessed PC |
| fe_v1 | input | 1 | Lane 1 push valid |
| fe_instr1 | input | IW | Lane 1 instruction |
| fe_pc1 | input | AW | Lane 1 guessed PC |
| fetch_ready | output | 1 | At least two slots free and not restarting |
| head_valid | output | 1 | Queue holds at least one entry |
| head_instr | output | IW | Instruction at the head |
| head_pc | output | AW | Guessed PC at the head |
| deq | input | 1 | Back end consumes the head entry |
| res_valid | input | 1 | Back end presents a resolved next PC |
| res_pc | input | AW | Architecturally correct next PC |
| restart_valid | output | 1 | One-cycle restart pulse |
| restart_pc | output | AW | Address at which fetching must restart |

## Verification
The hardest situation to reach is a mismatch in a cycle where a dual push and a `deq` arrive as well. It must be followed at once by pushes in the restart cycle. Both are needed to show that the flush wins and that the restart window drops wrong-path traffic. The bench first fills the queue partly. In one cycle it then drives a differing resolved PC, a dequeue and a valid pair. In the very next cycle it drives another pair. It then confirms that the head stays invalid and that fresh pushes afterwards come out in order.

// File: rtl/fq_pkg.sv
package fq_pkg;
    typedef enum logic [0:0] {
        S_RUN     = 1'b0,
        S_RESTART = 1'b1
    } fq_state_e;
endpackage

// File: rtl/fq_lane.sv
// One storage lane: two write ports (older entry on port 0), one read port.
module fq_lane #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0,
    input  logic          we1,
    input  logic [PW-1:0] waddr0,
    input  logic [PW-1:0] waddr1,
    input  logic          swap,
    input  logic [W-1:0]  din_a,
    input  logic [W-1:0]  din_b,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  dout
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] port0_data;

    always_comb begin
        port0_data = swap ? din_b : din_a;
    end

    always_ff @(posedge clk) begin
        if (we0) begin
            mem[waddr0] <= port0_data;
        end
        if (we1) begin
            mem[waddr1] <= din_b;
        end
    end

    always_comb begin
        dout = mem[raddr];
    end

    // Second port is only used as the younger half of a pair
    assert_pair_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we1 |-> (we0 && !swap && (waddr1 != waddr0)));
endmodule

// File: rtl/fq_ctrl.sv
// Pointer, occupancy and restart control for the decoupled fetch queue.
module fq_ctrl
    import fq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fe_v0,
    input  logic          fe_v1,
    input  logic          deq,
    input  logic          res_valid,
    input  logic [AW-1:0] res_pc,
    input  logic [AW-1:0] head_pc,
    output logic          we0,
    output logic          we1,
    output logic [PW-1:0] waddr0,
    output logic [PW-1:0] waddr1,
    output logic          swap,
    output logic [PW-1:0] raddr,
    output logic          head_valid,
    output logic          fetch_ready,
    output logic          restart_valid,
    output logic [AW-1:0] restart_pc
);
    fq_state_e     state_q, state_d;
    logic [CW-1:0] count_q;
    logic [PW-1:0] wr_q, rd_q;
    logic [AW-1:0] rpc_q;

    logic          in_run;
    logic          mismatch;
    logic          accept;
    logic          pop_ok;
    logic [CW-1:0] n_push;
    logic [CW-1:0] free_slots;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: MISMATCH and RESUME transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:     if (mismatch) state_d = S_RESTART;
            S_RESTART: state_d = S_RUN;
            default:   state_d = S_RUN;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        in_run        = (state_q == S_RUN);
        free_slots    = CW'(DEPTH) - count_q;
        head_valid    = (count_q != '0);
        mismatch      = in_run && res_valid && head_valid && (res_pc != head_pc);
        fetch_ready   = in_run && (free_slots >= CW'(2));
        accept        = fetch_ready && !mismatch;
        n_push        = accept ? (CW'(fe_v0) + CW'(fe_v1)) : '0;
        pop_ok        = deq && head_valid && !mismatch;
        we0           = accept && (fe_v0 || fe_v1);
        we1           = accept && fe_v0 && fe_v1;
        swap          = !fe_v0;
        waddr0        = wr_q;
        waddr1        = wr_q + PW'(1);
        raddr         = rd_q;
        restart_valid = (state_q == S_RESTART);
        restart_pc    = rpc_q;
    end

    // Pointers and occupancy; flush wins over push and pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            rpc_q   <= '0;
        end else if (mismatch) begin
            count_q <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            rpc_q   <= res_pc;
        end else begin
            count_q <= count_q + n_push - CW'(pop_ok);
            wr_q    <= wr_q + PW'(n_push);
            rd_q    <= rd_q + PW'(pop_ok);
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    assert_restart_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |=> !restart_valid);

    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && mismatch) |=> (!head_valid && restart_valid && restart_pc == $past(res_pc)));

    assert_restart_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> (!fetch_ready && !head_valid));

    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && !fe_v0 && !fe_v1) |=> !head_valid);

    assert_empty_resolve_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !head_valid) |=> !restart_valid);
endmodule

// File: rtl/fetch_decouple_q.sv
module fetch_decouple_q #(
    parameter int DEPTH = 8,
    parameter int IW    = 32,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fe_v0,
    input  logic [IW-1:0] fe_instr0,
    input  logic [AW-1:0] fe_pc0,
    input  logic          fe_v1,
    input  logic [IW-1:0] fe_instr1,
    input  logic [AW-1:0] fe_pc1,
    output logic          fetch_ready,
    output logic          head_valid,
    output logic [IW-1:0] head_instr,
    output logic [AW-1:0] head_pc,
    input  logic          deq,
    input  logic          res_valid,
    input  logic [AW-1:0] res_pc,
    output logic          restart_valid,
    output logic [AW-1:0] restart_pc
);
    logic          we0, we1, swap;
    logic [PW-1:0] waddr0, waddr1, raddr;

    fq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fe_v0(fe_v0), .fe_v1(fe_v1), .deq(deq),
        .res_valid(res_valid), .res_pc(res_pc), .head_pc(head_pc),
        .we0(we0), .we1(we1), .waddr0(waddr0), .waddr1(waddr1),
        .swap(swap), .raddr(raddr), .head_valid(head_valid),
        .fetch_ready(fetch_ready), .restart_valid(restart_valid),
        .restart_pc(restart_pc)
    );

    fq_lane #(.W(IW), .DEPTH(DEPTH)) u_instr_lane (
        .clk(clk), .rst_n(rst_n), .we0(we0), .we1(we1),
        .waddr0(waddr0), .waddr1(waddr1), .swap(swap),
        .din_a(fe_instr0), .din_b(fe_instr1), .raddr(raddr), .dout(head_instr)
    );

    fq_lane #(.W(AW), .DEPTH(DEPTH)) u_pc_lane (
        .clk(clk), .rst_n(rst_n), .we0(we0), .we1(we1),
        .waddr0(waddr0), .waddr1(waddr1), .swap(swap),
        .din_a(fe_pc0), .din_b(fe_pc1), .raddr(raddr), .dout(head_pc)
    );
endmodule

// File: tb/fetch_decouple_q_bench.sv
module fetch_decouple_q_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fe_v0 = 1'b0, fe_v1 = 1'b0;
    logic [31:0] fe_instr0 = '0, fe_instr1 = '0, fe_pc0 = '0, fe_pc1 = '0;
    logic        fetch_ready, head_valid, restart_valid;
    logic [31:0] head_instr, head_pc, restart_pc;
    logic        deq = 1'b0, res_valid = 1'b0;
    logic [31:0] res_pc = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fetch_decouple_q u_fetch_decouple_q (
        .clk(clk), .rst_n(rst_n),
        .fe_v0(fe_v0), .fe_instr0(fe_instr0), .fe_pc0(fe_pc0),
        .fe_v1(fe_v1), .fe_instr1(fe_instr1), .fe_pc1(fe_pc1),
        .fetch_ready(fetch_ready), .head_valid(head_valid),
        .head_instr(head_instr), .head_pc(head_pc),
        .deq(deq), .res_valid(res_valid), .res_pc(res_pc),
        .restart_valid(restart_valid), .restart_pc(restart_pc)
    );

    function automatic logic [31:0] ins(int n);
        return 32'hA000_0000 + 32'(n);
    endfunction
    function automatic logic [31:0] pcv(int n);
        return 32'h0000_1000 + 32'(4 * n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic push(input bit v0, input int n0, input bit v1, input int n1);
        fe_v0 = v0; fe_instr0 = ins(n0); fe_pc0 = pcv(n0);
        fe_v1 = v1; fe_instr1 = ins(n1); fe_pc1 = pcv(n1);
        tick();
        fe_v0 = 1'b0; fe_v1 = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input int n);
        chk({tag, " head_valid"}, 32'(head_valid), 32'd1);
        chk({tag, " head_instr"}, head_instr, ins(n));
        chk({tag, " head_pc"}, head_pc, pcv(n));
        deq = 1'b1;
        tick();
        deq = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 head_valid", 32'(head_valid), 32'd0);
        chk("R1 restart_valid", 32'(restart_valid), 32'd0);
        chk("R1 fetch_ready", 32'(fetch_ready), 32'd1);
    endtask

    task automatic t_order();
        push(1, 0, 1, 1);
        push(1, 2, 1, 3);
        pop_expect("R2 order", 0);
        pop_expect("R2 order", 1);
        pop_expect("R2 order", 2);
        pop_expect("R2 order", 3);
        chk("R2 empty after drain", 32'(head_valid), 32'd0);
    endtask

    task automatic t_single_lane();
        push(1, 10, 0, 99);
        push(0, 98, 1, 11);
        pop_expect("R3 lane0 alone", 10);
        pop_expect("R3 lane1 alone", 11);
        chk("R3 exactly two entries", 32'(head_valid), 32'd0);
    endtask

    task automatic t_full();
        for (int k = 0; k < 4; k++) begin
            chk("R4 ready with room", 32'(fetch_ready), 32'd1);
            push(1, 20 + 2 * k, 1, 21 + 2 * k);
        end
        chk("R4 ready low when full", 32'(fetch_ready), 32'd0);
        push(1, 90, 1, 91);
        pop_expect("R4 full drain", 20);
        chk("R4 ready low one free", 32'(fetch_ready), 32'd0);
        pop_expect("R4 full drain", 21);
        chk("R4 ready high two free", 32'(fetch_ready), 32'd1);
        for (int k = 2; k < 8; k++) pop_expect("R4 dropped push absent", 20 + k);
        chk("R4 empty", 32'(head_valid), 32'd0);
    endtask

    task automatic t_pop_empty();
        deq = 1'b1;
        tick();
        tick();
        deq = 1'b0;
        chk("R5 pop empty", 32'(head_valid), 32'd0);
        push(1, 30, 0, 0);
        pop_expect("R5 pop after empty pops", 30);
        chk("R5 one removed", 32'(head_valid), 32'd0);
    endtask

    task automatic t_mixed();
        push(1, 40, 0, 0);
        deq = 1'b1;
        push(1, 41, 1, 42);
        deq = 1'b0;
        pop_expect("R11 push+pop", 41);
        pop_expect("R11 push+pop", 42);
        chk("R11 occupancy", 32'(head_valid), 32'd0);
    endtask

    task automatic t_resolve_match();
        push(1, 50, 1, 51);
        res_valid = 1'b1; res_pc = pcv(50);
        tick();
        res_valid = 1'b0;
        chk("R6 no restart", 32'(restart_valid), 32'd0);
        pop_expect("R6 contents kept", 50);
        pop_expect("R6 contents kept", 51);
    endtask

    task automatic t_resolve_empty();
        res_valid = 1'b1; res_pc = 32'hDEAD_0000;
        tick();
        res_valid = 1'b0;
        chk("R10 no restart when empty", 32'(restart_valid), 32'd0);
    endtask

    task automatic t_mismatch();
        push(1, 60, 1, 61);
        push(1, 62, 0, 0);
        res_valid = 1'b1; res_pc = 32'h0000_8000; deq = 1'b1;
        push(1, 63, 1, 64);
        res_valid = 1'b0; deq = 1'b0;
        chk("R7 restart pulse", 32'(restart_valid), 32'd1);
        chk("R7 restart pc", restart_pc, 32'h0000_8000);
        chk("R8 flushed", 32'(head_valid), 32'd0);
        chk("R9 ready low in restart", 32'(fetch_ready), 32'd0);
        push(1, 65, 1, 66);
        chk("R7 pulse one cycle", 32'(restart_valid), 32'd0);
        chk("R9 restart push dropped", 32'(head_valid), 32'd0);
        chk("R9 ready again", 32'(fetch_ready), 32'd1);
        push(1, 70, 1, 71);
        pop_expect("R9 resume order", 70);
        pop_expect("R9 resume order", 71);
        chk("R8 nothing stale", 32'(head_valid), 32'd0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_single_lane();
        t_full();
        t_pop_empty();
        t_mixed();
        t_resolve_match();
        t_resolve_empty();
        t_mismatch();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule